// File: doc/BRIEF.md
# Bank Conflict Gate for a Multi-Bank Array

This block sits in front of a storage array that is split into a power-of-two number of banks. Each cycle it sees at most one request, made of a valid strobe and a set index. It picks the bank from the low bits of the index and answers in the same cycle: grant if the bank can start a new access, reject if the bank is still occupied by an earlier one. The requester retries a rejected request itself.

A grant to an idle bank keeps that bank occupied for the configured access latency. Each bank holds a small down-counter of remaining occupied cycles and the index that claimed it. A request that comes in the cycle right after the claim and carries the same index is treated as the same access issued again. It is granted and leaves the bank unchanged. When the latency parameter is zero, banks are never occupied and every request is granted.

Top module: `bank_gate`

## Requirements
- R1: After a synchronous active-high reset, every bank is idle, so the first request to any bank is granted.
- R2: `bank_sel` equals `req_index` modulo `NUM_BANKS`, which is the low log2(`NUM_BANKS`) bits of the index. It follows the index whether or not `req_valid` is high.
- R3: With `NUM_BANKS` = 1, `bank_sel` is 0 for every index, and all requests contend for that single bank.
- R4: A grant in cycle t to an idle bank occupies that bank through cycle t+`LATENCY`-1. During cycles t+1 to t+`LATENCY`-1, a request to that bank is rejected unless R6 applies.
- R5: In cycle t+`LATENCY` the bank is idle again and a request with any index to it is granted.
- R6: In cycle t+1 only, a request to the bank with the same index as the claiming request is granted and does not change the bank's timing. The same index in cycle t+2 or later, while the bank is still occupied, is rejected.
- R7: Banks are independent. Occupying one bank does not affect grants to the others.
- R8: With `LATENCY` = 0, every valid request is granted, whatever its index or what came before it.
- R9: When `req_valid` is low, `grant` and `reject` are both low. When it is high, exactly one of them is high.
- R10: A rejected request and an idle cycle leave the bank state unchanged. A rejection does not extend the occupied window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_index | input | IDX_W | Set index of the request |
| grant | output | 1 | Request may start this cycle |
| reject | output | 1 | Request conflicts with an occupied bank |
| bank_sel | output | max(1, log2(NUM_BANKS)) | Bank the index maps to |

## Verification
The bench drives the same stimulus into three copies of the block. The main copy has four banks and a latency of three. Four banks means indices that differ only above bit 1 collide, and latency three gives a window long enough to show the same-index repeat one cycle after the claim next to a rejected repeat two cycles after it. A copy with one bank puts every index onto bank 0, which exposes wrong modulo handling. A copy with latency zero covers the path that always grants.

// File: rtl/bank_gate.sv
module bank_gate #(
  parameter int NUM_BANKS = 4,
  parameter int LATENCY   = 3,
  parameter int IDX_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  output logic             grant,
  output logic             reject,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] bank_sel
);
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam int LOAD_I = (LATENCY > 1) ? LATENCY - 1 : 0;
  localparam logic [CW-1:0] LOAD = CW'(LOAD_I);

  logic [NUM_BANKS-1:0] busy_vec;
  logic [NUM_BANKS-1:0] dup_vec;
  logic hit, dup, claim;

  generate
    if (NUM_BANKS > 1) begin : g_multi
      assign bank_sel = req_index[BW-1:0];
    end else begin : g_single
      assign bank_sel = '0;
    end
  endgenerate

  assign hit   = busy_vec[bank_sel];
  assign dup   = dup_vec[bank_sel];
  assign grant = req_valid && ((LATENCY == 0) || !hit || dup);
  assign reject = req_valid && !grant;
  assign claim = grant && !hit && (LATENCY > 1);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CW-1:0]    cnt;
      logic             fresh;
      logic [IDX_W-1:0] owner;

      assign busy_vec[b] = (cnt != '0);
      assign dup_vec[b]  = fresh && (owner == req_index);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt   <= '0;
          fresh <= 1'b0;
          owner <= '0;
        end else begin
          fresh <= 1'b0;
          if (claim && (32'(bank_sel) == b)) begin
            cnt   <= LOAD;
            fresh <= 1'b1;
            owner <= req_index;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

module bank_gate_chk #(
  parameter int NUM_BANKS = 4,
  parameter int LATENCY   = 3,
  parameter int IDX_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [IDX_W-1:0] req_index,
  input logic             grant,
  input logic             reject,
  input logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] bank_sel,
  input logic [NUM_BANKS-1:0] busy_vec
);
  // R9
  resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (grant != reject));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!grant && !reject));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (busy_vec == '0));

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      // R10
      stay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_vec[b] && !(grant && (32'(bank_sel) == b))) |=> !busy_vec[b]);
    end
    if (LATENCY == 0) begin : g_zero
      // R8
      always_grant_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> grant);
    end
    if (LATENCY >= 3) begin : g_long
      // R4
      next_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(req_valid && grant) && req_valid &&
         (bank_sel == $past(bank_sel)) && (req_index != $past(req_index)))
        |-> reject);
    end
  endgenerate
endmodule

bind bank_gate bank_gate_chk #(.NUM_BANKS(NUM_BANKS), .LATENCY(LATENCY), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
  .grant(grant), .reject(reject), .bank_sel(bank_sel), .busy_vec(busy_vec)
);

// File: tb/bank_gate_test.sv
module bank_gate_test;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [15:0] req_index = '0;

  logic g_m, r_m, g_z, r_z, g_o, r_o;
  logic [1:0] b_m, b_z;
  logic [0:0] b_o;

  always #5 clk = ~clk;

  bank_gate #(.NUM_BANKS(4), .LATENCY(LAT), .IDX_W(16)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .grant(g_m), .reject(r_m), .bank_sel(b_m));
  bank_gate #(.NUM_BANKS(4), .LATENCY(0), .IDX_W(16)) uut_zero (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .grant(g_z), .reject(r_z), .bank_sel(b_z));
  bank_gate #(.NUM_BANKS(1), .LATENCY(LAT), .IDX_W(16)) uut_one (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
    .grant(g_o), .reject(r_o), .bank_sel(b_o));

  typedef struct {
    string tag;
    logic [1:0] m;
    logic [1:0] z;
    logic [1:0] o;
    logic [1:0] bank;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  bit used[2][4];
  int st[2][4];
  int en[2][4];
  logic [15:0] own[2][4];

  function automatic void clear_model();
    for (int k = 0; k < 2; k++)
      for (int b = 0; b < 4; b++) begin
        used[k][b] = 0; st[k][b] = 0; en[k][b] = 0; own[k][b] = '0;
      end
  endfunction

  function automatic logic [1:0] model(int k, int nb, bit v, logic [15:0] idx);
    int b;
    if (!v) return 2'b00;
    b = int'(idx) % nb;
    if (used[k][b] && cyc <= en[k][b]) begin
      if (cyc == st[k][b] + 1 && own[k][b] == idx) return 2'b10;
      return 2'b01;
    end
    used[k][b] = 1; st[k][b] = cyc; en[k][b] = cyc + LAT - 1; own[k][b] = idx;
    return 2'b10;
  endfunction

  task automatic step(input bit v, input logic [15:0] idx, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = v;
    req_index = idx;
    it.tag  = tag;
    it.m    = model(0, 4, v, idx);
    it.o    = model(1, 1, v, idx);
    it.z    = v ? 2'b10 : 2'b00;
    it.bank = idx[1:0];
    q.push_back(it);
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    cyc = 0;
  endtask

  task automatic cmp(input string tag, input string who, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: {grant,reject,bank} actual %b expected %b", tag, who, act, exp);
    end
  endtask

  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      if (q.size() > 0) begin
        it = q.pop_front();
        cmp(it.tag, "main", {g_m, r_m, b_m}, {it.m, it.bank});
        cmp("R8", "zero", {g_z, r_z, b_z}, {it.z, it.bank});
        cmp("R3", "one", {g_o, r_o, 2'(b_o)}, {it.o, 2'b00});
      end
    end
  end

  initial begin
    clear_model();
    do_reset();
    step(0, 16'h0005, "R9");
    step(1, 16'h0005, "R1");
    step(1, 16'h0009, "R4");
    step(1, 16'h0005, "R6");
    step(1, 16'h0009, "R5");
    step(0, 16'h0000, "R9");
    step(0, 16'h0000, "R9");
    step(1, 16'h0006, "R2");
    step(1, 16'h0006, "R6");
    step(1, 16'h0006, "R6");
    step(1, 16'h0006, "R5");
    step(0, 16'h0000, "R9");
    step(0, 16'h0000, "R9");
    step(1, 16'h0002, "R7");
    step(1, 16'h0003, "R7");
    step(1, 16'h0007, "R7");
    step(1, 16'h0000, "R7");
    step(0, 16'h0000, "R9");
    step(0, 16'h0000, "R9");
    step(1, 16'h000C, "R2");
    step(1, 16'h0010, "R10");
    step(0, 16'h0010, "R10");
    step(1, 16'h0010, "R10");
    step(1, 16'hFFFF, "R2");
    step(1, 16'hFFFE, "R2");
    step(1, 16'h1234, "R8");
    do_reset();
    step(1, 16'h0011, "R1");
    step(1, 16'h0015, "R4");
    do_reset();
    step(1, 16'h0015, "R1");
    step(0, 16'h0000, "R9");
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule